// File: doc/BRIEF.md
# Eight-bit Ling carry-select adder

The block adds two 8-bit operands and a carry-in, and returns an 8-bit sum and a carry-out. Carries do not ripple bit by bit. The operands are split into two 4-bit groups. Each group forms a Ling pseudo-generate directly from the raw operand bits. This is the group generate with the propagate term of the group's top bit left out. Each group also forms a pseudo-propagate, which is the group propagate moved down by one bit position.

The carry-in is treated as an extra bit below bit 0, with both operand inputs tied to it, so it enters the lower group as a generate. Inside each group, the carry into every bit is prepared twice: once for an incoming pseudo carry of 0 and once for 1. The real pseudo carry then picks between the two. A separate cell classifies each bit as generate, propagate or kill. A fused select-and-XOR stage forms each sum bit from the propagate and the chosen carry. The carry-out is the top bit's OR-propagate ANDed with the long pseudo carry over all eight bits.

The outputs can be taken straight from the logic, or through one register stage that clears on reset. The register is the default.

Top module: `ling_add8`

## Requirements
- R1: For every bit, exactly one of generate (a&b), propagate (a^b) and kill (~a&~b) is asserted.
- R2: The carry-in acts as a generate at a pseudo position below bit 0. With both operands zero, the sum equals the carry-in in bit 0, zero elsewhere, and the carry-out is 0.
- R3: The carry out of operand bits 0..3 equals (a[3]|b[3]) ANDed with the lower group's pseudo-generate combined with the carry-in. Sum bit 4 reflects it.
- R4: Upper-group carries (into bits 4..7) are taken from the candidate that matches the lower group's pseudo carry. A carry that enters at bit 0 propagates through all eight bits.
- R5: Each sum bit equals a[i]^b[i] XOR the carry into bit i. With no carries, the sum is a^b.
- R6: The carry-out equals (a[7]|b[7]) AND the 8-bit long pseudo carry, which is the carry out of bit 7.
- R7: {cout_o, sum_o} equals a_i + b_i + cin_i for all 2^17 input combinations.
- R8: With REG_OUT=1, the outputs present the result one clock edge after the inputs are sampled. While rst_ni is low, the outputs are 0.
- R9: Setting PROP_XOR to 1 (XOR propagate) or 0 (OR propagate) in the group logic gives identical results for every input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Active-low asynchronous reset, clears outputs |
| a_i | input | 8 | First operand |
| b_i | input | 8 | Second operand |
| cin_i | input | 1 | Carry-in |
| sum_o | output | 8 | Sum, bit 0 least significant |
| cout_o | output | 1 | Carry-out |

## Verification
A wrong pseudo-generate or pseudo-propagate in one group shows up as a wrong sum bit at that group's top bit or above, or as a wrong carry-out. It appears on the very next registered output. A select that picks the wrong candidate corrupts only bits 4..7, and only for operands where the lower group produces or blocks a carry. That is why vectors that straddle the group boundary, and the exhaustive sweep, matter. Both propagate variants are compared with the same reference in the same cycle, so a divergence between them is reported at once.

// File: rtl/ling_pkg.sv
package ling_pkg;
  localparam int unsigned ADD_W = 8;
  localparam int unsigned GRP_W = 4;

  typedef struct packed {
    logic gen;
    logic prop;
    logic kill;
  } gpk_t;
endpackage

// File: rtl/lg_bit_class.sv
module lg_bit_class
  import ling_pkg::*;
#(
  parameter int unsigned W = ADD_W
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output gpk_t [W-1:0] cls_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign cls_o[i].gen  = a_i[i] & b_i[i];
    assign cls_o[i].prop = a_i[i] ^ b_i[i];
    assign cls_o[i].kill = ~(a_i[i] | b_i[i]);
  end
endmodule

// File: rtl/lg_group.sv
// One valency-GW Ling group, computed from raw operand bits.
module lg_group #(
  parameter int unsigned GW       = 4,
  parameter bit          PROP_XOR = 1'b1
) (
  input  logic [GW-1:0] a_i,
  input  logic [GW-1:0] b_i,
  input  logic          t_below_i,  // OR-propagate of the bit under the group
  output logic          h_o,        // pseudo-generate, top propagate dropped
  output logic          i_o,        // pseudo-propagate, shifted down one bit
  output logic [GW-1:0] c0_o,       // carry into each bit, pseudo carry in = 0
  output logic [GW-1:0] c1_o        // carry into each bit, pseudo carry in = 1
);
  logic [GW-1:0] g, t;

  for (genvar k = 0; k < GW; k++) begin : g_gt
    assign g[k] = a_i[k] & b_i[k];
    if (PROP_XOR) begin : g_x
      assign t[k] = a_i[k] ^ b_i[k];
    end else begin : g_o
      assign t[k] = a_i[k] | b_i[k];
    end
  end

  always_comb begin
    logic run, tr;
    run = 1'b0;
    tr  = 1'b1;
    for (int k = 0; k < GW; k++) begin
      c0_o[k] = run;
      c1_o[k] = run | (tr & t_below_i);
      run     = g[k] | (t[k] & run);
      tr      = tr & t[k];
    end
  end

  assign h_o = g[GW-1] | c0_o[GW-1];
  always_comb begin
    logic tp;
    tp = t_below_i;
    for (int k = 0; k < GW-1; k++) tp = tp & (a_i[k] | b_i[k]);
    i_o = tp;
  end
endmodule

// File: rtl/lg_sum_sel.sv
// Fused carry select and XOR per bit.
module lg_sum_sel #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] p_i,
  input  logic [W-1:0] c0_i,
  input  logic [W-1:0] c1_i,
  input  logic [W-1:0] sel_i,
  output logic [W-1:0] sum_o
);
  for (genvar i = 0; i < W; i++) begin : g_sum
    assign sum_o[i] = (sel_i[i] & (p_i[i] ^ c1_i[i])) |
                      (~sel_i[i] & (p_i[i] ^ c0_i[i]));
  end
endmodule

// File: rtl/ling_add8.sv
module ling_add8
  import ling_pkg::*;
#(
  parameter int unsigned W        = ADD_W,
  parameter int unsigned GW       = GRP_W,
  parameter bit          PROP_XOR = 1'b1,
  parameter bit          REG_OUT  = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  localparam int unsigned NG = W / GW;

  gpk_t [W-1:0] cls;
  logic [NG:0]  h_chain;
  logic [NG-1:0] h_grp, i_grp;
  logic [W-1:0] c0, c1, sel, p;
  logic [W-1:0] sum_c;
  logic         cout_c;

  lg_bit_class #(.W(W)) u_cls (
    .a_i  (a_i),
    .b_i  (b_i),
    .cls_o(cls)
  );

  assign h_chain[0] = cin_i;

  for (genvar gi = 0; gi < NG; gi++) begin : g_grp
    logic t_below;
    if (gi == 0) begin : g_lo
      assign t_below = cin_i;  // pseudo bit: both inputs tied to carry-in
    end else begin : g_hi
      assign t_below = a_i[gi*GW-1] | b_i[gi*GW-1];
    end

    lg_group #(.GW(GW), .PROP_XOR(PROP_XOR)) u_grp (
      .a_i      (a_i[gi*GW +: GW]),
      .b_i      (b_i[gi*GW +: GW]),
      .t_below_i(t_below),
      .h_o      (h_grp[gi]),
      .i_o      (i_grp[gi]),
      .c0_o     (c0[gi*GW +: GW]),
      .c1_o     (c1[gi*GW +: GW])
    );

    assign sel[gi*GW +: GW] = {GW{h_chain[gi]}};
    assign h_chain[gi+1]    = h_grp[gi] | (i_grp[gi] & h_chain[gi]);
  end

  for (genvar i = 0; i < W; i++) begin : g_p
    assign p[i] = cls[i].prop;
  end

  lg_sum_sel #(.W(W)) u_sum (
    .p_i  (p),
    .c0_i (c0),
    .c1_i (c1),
    .sel_i(sel),
    .sum_o(sum_c)
  );

  assign cout_c = (a_i[W-1] | b_i[W-1]) & h_chain[NG];

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sum_o  <= '0;
        cout_o <= 1'b0;
      end else begin
        sum_o  <= sum_c;
        cout_o <= cout_c;
      end
    end
  end else begin : g_comb
    assign sum_o  = sum_c;
    assign cout_o = cout_c;
  end

  // ---------------- assertions ----------------
  logic past_valid;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_valid <= 1'b0;
    else         past_valid <= 1'b1;
  end

  logic [W:0] ref_sum;
  logic [GW:0] ref_lo;
  assign ref_sum = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
  assign ref_lo  = {1'b0, a_i[GW-1:0]} + {1'b0, b_i[GW-1:0]} + {{GW{1'b0}}, cin_i};

  for (genvar i = 0; i < W; i++) begin : g_ast_cls
    AST_GPK_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones({cls[i].gen, cls[i].prop, cls[i].kill}) == 1); // R1
  end

  AST_CIN_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_i == '0 && b_i == '0) |-> (sum_c == {{(W-1){1'b0}}, cin_i} && !cout_c)); // R2

  AST_LO_CARRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((a_i[GW-1] | b_i[GW-1]) & h_chain[1]) == ref_lo[GW]); // R3

  AST_HI_SELECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (h_chain[1] ? c1[GW] : c0[GW]) == (ref_lo[GW] ? 1'b1 : 1'b0)); // R4

  AST_SUM_XOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sum_c ^ (a_i ^ b_i)) == (ref_sum[W-1:0] ^ a_i ^ b_i)); // R5

  AST_COUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cout_c == ref_sum[W]); // R6

  AST_ADD_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    {cout_c, sum_c} == ref_sum); // R7

  if (REG_OUT) begin : g_ast_reg
    AST_REG_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      past_valid |-> ({cout_o, sum_o} == $past({cout_c, sum_c}))); // R8
  end
endmodule

// File: tb/sim_ling_add8.sv
module sim_ling_add8;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 150000;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] a = '0, b = '0;
  logic       cin = 1'b0;
  logic [7:0] sum0, sum1;
  logic       cout0, cout1;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [8:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  ling_add8 #(.PROP_XOR(1'b1), .REG_OUT(1'b1)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .a_i(a), .b_i(b), .cin_i(cin),
    .sum_o(sum0), .cout_o(cout0)
  );

  ling_add8 #(.PROP_XOR(1'b0), .REG_OUT(1'b1)) u1 (
    .clk_i(clk), .rst_ni(rst_ni), .a_i(a), .b_i(b), .cin_i(cin),
    .sum_o(sum1), .cout_o(cout1)
  );

  task automatic check(string tag, logic [8:0] got, logic [8:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic compare_pending();
    if (exp_q.size() > 0) begin
      logic [8:0] e;
      string      t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, {cout0, sum0}, e);
      check({t, " R9 or-propagate variant"}, {cout1, sum1}, e);
    end
  endtask

  task automatic apply(logic [7:0] av, logic [7:0] bv, logic cv, string tag);
    @(negedge clk);
    compare_pending();
    a   = av;
    b   = bv;
    cin = cv;
    exp_q.push_back({1'b0, av} + {1'b0, bv} + {8'd0, cv});
    tag_q.push_back(tag);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    a = 8'hFF; b = 8'hFF; cin = 1'b1;
    repeat (3) @(negedge clk);
    check("R8 reset clears u0", {cout0, sum0}, 9'h000);
    check("R8 reset clears u1", {cout1, sum1}, 9'h000);
    rst_ni = 1'b1;

    apply(8'h00, 8'h00, 1'b1, "R2 carry-in only");
    apply(8'h00, 8'h00, 1'b0, "R2 all zero");
    apply(8'hFF, 8'hFF, 1'b1, "R1 all generate");
    apply(8'h00, 8'h00, 1'b0, "R1 all kill");
    apply(8'h0F, 8'h01, 1'b0, "R3 carry out of bit 3");
    apply(8'h07, 8'h08, 1'b1, "R3 carry-in through lower group");
    apply(8'hFF, 8'h00, 1'b1, "R4 carry through all bits");
    apply(8'hF0, 8'h0F, 1'b1, "R4 lower carry selects upper candidate");
    apply(8'hF8, 8'h07, 1'b0, "R4 no lower carry");
    apply(8'h5A, 8'h21, 1'b0, "R5 no carries");
    apply(8'h80, 8'h80, 1'b0, "R6 top generate");
    apply(8'hC0, 8'h40, 1'b0, "R6 carry from bit 6");
    // registered output tracks consecutive changing vectors
    apply(8'h12, 8'h34, 1'b0, "R8 back-to-back 1");
    apply(8'hFE, 8'h01, 1'b1, "R8 back-to-back 2");

    for (int v = 0; v < (1 << 17); v++) begin
      apply(v[7:0], v[15:8], v[16], "R7 exhaustive");
    end

    @(negedge clk);
    compare_pending();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule